// File: doc/BRIEF.md
# Serial Byte Link

The block joins two byte-wide right-shifting registers into a one-wire transfer path. A byte is placed in parallel into the sending register, and each enabled clock edge moves every register one place toward bit 0. The bit that leaves bit 0 of the sender enters bit 7 of the receiver. Eight enabled edges therefore carry the whole byte across, and the receiver ends up holding it in its original bit order.

Both registers share one clock, one shift enable and one asynchronous clear. The receiver's previous contents do not matter, because all eight of its bits are replaced during a transfer. The serial input of the sender is brought out as a port. A controller normally ties it low, so the sender drains to zero. A small counter, armed by each load, raises a one-cycle completion strobe after the eighth shift. A controller may then read the received byte or start the next one.

Top module: `serial_byte_link`

## Requirements
- R1: When `load_tx` is high at a rising edge of `clk`, `tx_q` takes the value of `par_in` at that edge.
- R2: When `shift` is high and `load_tx` is low at a rising edge, `tx_q` becomes `{ser_in_tx, tx_q[7:1]}`: the serial input enters bit 7 and every other bit moves one place toward bit 0. With `ser_in_tx` at 0, a load of 0x85 drains as 0x42, 0x21, 0x10, 0x08, 0x04, 0x02, 0x01, 0x00.
- R3: The receiver's serial input is `tx_q[0]`. On each edge where `shift` is high, `rx_q` becomes `{tx_q[0], rx_q[7:1]}`. From `rx_q` = 0x00 with 0x85 loaded, the receiver reads 0x80, 0x40, 0xA0, 0x50, 0x28, 0x14, 0x0A, 0x85.
- R4: At an edge where both `load_tx` and `shift` are low, `tx_q` and `rx_q` keep their values.
- R5: Eight shifts after a load, `rx_q` equals the loaded byte, whatever it held before. At the same point, `tx_q` holds the eight serial-input bits that entered it; with `ser_in_tx` at 1 this value is 0xFF.
- R6: `xfer_done` is high for exactly the one cycle that follows the eighth shift after the most recent load. A new load restarts the count. Shifts made when no load has armed the counter never raise `xfer_done`.
- R7: While `arst` is high, `tx_q`, `rx_q` and `xfer_done` are 0 at once, without waiting for a clock edge.
- R8: When `load_tx` and `shift` are both high at an edge, `tx_q` takes `par_in`, so the load wins. `rx_q` still shifts in the old `tx_q[0]`, and the shift count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| load_tx | input | 1 | Parallel load of the sender |
| par_in | input | 8 | Byte to send |
| shift | input | 1 | Shift enable, shared by both registers |
| ser_in_tx | input | 1 | Serial input of the sender, normally 0 |
| tx_q | output | 8 | Sender contents |
| rx_q | output | 8 | Receiver contents |
| xfer_done | output | 1 | One-cycle strobe after the eighth shift |

## Verification
The clocked properties assume that `arst`, `load_tx`, `shift` and `ser_in_tx` are synchronous to `clk` and settled at each rising edge. The clear property assumes that `arst` changes away from an edge. The stimulus changes every input just after a falling edge and samples the outputs at the next falling edge. The one exception is the clear scenario, which raises `arst` at a quarter period after the falling edge, well clear of the rising edge.

// File: rtl/serial_link_pkg.sv
package serial_link_pkg;
  parameter int LINK_W = 8;
  typedef logic [LINK_W-1:0] word_t;

  // One right step: new bit enters the MSB, bit 0 falls out.
  function automatic word_t step_right(input word_t cur, input logic fill);
    return {fill, cur[LINK_W-1:1]};
  endfunction
endpackage

// File: rtl/link_shreg.sv
module link_shreg
  import serial_link_pkg::*;
(
  input  logic  clk,
  input  logic  arst,
  input  logic  load,
  input  word_t par_in,
  input  logic  shift,
  input  logic  ser_in,
  output word_t q
);
  word_t q_r;
  logic  do_load;
  logic  do_shift;

  assign do_load  = load;
  assign do_shift = shift & ~load;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          q_r <= '0;
    else if (do_load)  q_r <= par_in;
    else if (do_shift) q_r <= step_right(q_r, ser_in);
  end

  assign q = q_r;

  // R1 / R8: a load wins over a shift
  p_load_r1: assert property (@(posedge clk) disable iff (arst)
    load |=> q == $past(par_in));
  // R2: fill bit lands in the MSB, the rest move down
  p_shift_msb_r2: assert property (@(posedge clk) disable iff (arst)
    (shift && !load) |=> q[LINK_W-1] == $past(ser_in));
  p_shift_low_r2: assert property (@(posedge clk) disable iff (arst)
    (shift && !load) |=> q[LINK_W-2:0] == $past(q[LINK_W-1:1]));
  // R4: idle edge keeps contents
  p_hold_r4: assert property (@(posedge clk) disable iff (arst)
    (!shift && !load) |=> $stable(q));
  // R7: clear zeroes the register
  p_clear_r7: assert property (@(posedge clk) arst |-> q == '0);
endmodule

// File: rtl/link_shift_counter.sv
module link_shift_counter #(
  parameter int LEN = 8,
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic arst,
  input  logic load,
  input  logic shift,
  output logic done
);
  logic [CW-1:0] cnt;
  logic          armed;
  logic          done_r;
  logic          last_shift;

  assign last_shift = armed & shift & ~load & (cnt == CW'(LEN - 1));

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt    <= '0;
      armed  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= last_shift;
      if (load) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (armed && shift) begin
        cnt <= cnt + 1'b1;
        if (last_shift) armed <= 1'b0;
      end
    end
  end

  assign done = done_r;

  // R6: strobe is a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (arst)
    done |=> !done);
  // R6: strobe only follows a counted shift
  p_done_cause_r6: assert property (@(posedge clk) disable iff (arst)
    !(armed && shift && !load) |=> !done);
  // R7: clear drops the strobe
  p_done_clear_r7: assert property (@(posedge clk) arst |-> !done);
endmodule

// File: rtl/serial_byte_link.sv
module serial_byte_link
  import serial_link_pkg::*;
(
  input  logic              clk,
  input  logic              arst,
  input  logic              load_tx,
  input  logic [LINK_W-1:0] par_in,
  input  logic              shift,
  input  logic              ser_in_tx,
  output logic [LINK_W-1:0] tx_q,
  output logic [LINK_W-1:0] rx_q,
  output logic              xfer_done
);
  word_t tx_w;
  word_t rx_w;
  logic  wire_bit;   // the single link wire

  assign wire_bit = tx_w[0];

  link_shreg u_tx (
    .clk(clk), .arst(arst), .load(load_tx), .par_in(par_in),
    .shift(shift), .ser_in(ser_in_tx), .q(tx_w)
  );

  link_shreg u_rx (
    .clk(clk), .arst(arst), .load(1'b0), .par_in('0),
    .shift(shift), .ser_in(wire_bit), .q(rx_w)
  );

  link_shift_counter #(.LEN(LINK_W)) u_cnt (
    .clk(clk), .arst(arst), .load(load_tx), .shift(shift), .done(xfer_done)
  );

  assign tx_q = tx_w;
  assign rx_q = rx_w;

  // R3: receiver MSB takes the bit that left the sender
  p_link_r3: assert property (@(posedge clk) disable iff (arst)
    shift |=> rx_q[LINK_W-1] == $past(tx_q[0]));
  // R8: receiver shifts even when the sender loads
  p_rx_shift_on_load_r8: assert property (@(posedge clk) disable iff (arst)
    (shift && load_tx) |=> rx_q[LINK_W-2:0] == $past(rx_q[LINK_W-1:1]));
endmodule

// File: tb/serial_byte_link_test.sv
`timescale 1ns/1ps
module serial_byte_link_test;
  logic       clk = 1'b0;
  logic       arst = 1'b1;
  logic       load_tx = 1'b0;
  logic [7:0] par_in = '0;
  logic       shift = 1'b0;
  logic       ser_in_tx = 1'b0;
  logic [7:0] tx_q, rx_q;
  logic       xfer_done;
  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  serial_byte_link uut (
    .clk(clk), .arst(arst), .load_tx(load_tx), .par_in(par_in),
    .shift(shift), .ser_in_tx(ser_in_tx), .tx_q(tx_q), .rx_q(rx_q),
    .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, take one rising edge, return at the next falling edge.
  task automatic step(input logic l, input logic [7:0] d, input logic s, input logic si);
    load_tx = l; par_in = d; shift = s; ser_in_tx = si;
    @(posedge clk);
    @(negedge clk);
    load_tx = 1'b0; shift = 1'b0;
  endtask

  function automatic logic [7:0] mv(input logic [7:0] v, input logic b);
    logic [7:0] r;
    r = v >> 1;
    r[7] = b;
    return r;
  endfunction

  task automatic t_reset;
    chk("R7 reset tx", tx_q, 0);
    chk("R7 reset rx", rx_q, 0);
    chk("R7 reset done", xfer_done, 0);
    arst = 1'b0;
    @(negedge clk);
  endtask

  // Load a byte, then shift eight times, checking both registers and the strobe.
  task automatic t_transfer(input logic [7:0] b, input logic si);
    logic [7:0] et, er;
    et = tx_q; er = rx_q;
    step(1'b1, b, 1'b0, si);
    chk("R1 load", tx_q, b);
    chk("R4 rx idle during load", rx_q, er);
    et = b;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 8'h00, 1'b1, si);
      er = mv(er, et[0]);
      et = mv(et, si);
      chk("R2 tx step", tx_q, et);
      chk("R3 rx step", rx_q, er);
      chk("R6 done timing", xfer_done, (i == 7) ? 1 : 0);
    end
    chk("R5 rx holds byte", rx_q, b);
    chk("R5 tx drained", tx_q, si ? 8'hFF : 8'h00);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R6 done one cycle", xfer_done, 0);
  endtask

  task automatic t_known_sequence;
    logic [7:0] txs [8] = '{8'h42, 8'h21, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01, 8'h00};
    logic [7:0] rxs [8] = '{8'h80, 8'h40, 8'hA0, 8'h50, 8'h28, 8'h14, 8'h0A, 8'h85};
    step(1'b1, 8'h85, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R2 tx table", tx_q, txs[i]);
      chk("R3 rx table", rx_q, rxs[i]);
    end
  endtask

  task automatic t_hold;
    logic [7:0] t0, r0;
    step(1'b1, 8'hC3, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    t0 = tx_q; r0 = rx_q;
    for (int i = 0; i < 3; i++) step(1'b0, 8'hFF, 1'b0, 1'b1);
    chk("R4 tx hold", tx_q, t0);
    chk("R4 rx hold", rx_q, r0);
  endtask

  task automatic t_priority;
    logic [7:0] t0, r0;
    t0 = tx_q; r0 = rx_q;
    step(1'b1, 8'h5A, 1'b1, 1'b0);
    chk("R8 load wins", tx_q, 8'h5A);
    chk("R8 rx still shifts", rx_q, mv(r0, t0[0]));
    for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R8 count restarted", xfer_done, 0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R8 done after eighth", xfer_done, 1);
    step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_restart;
    step(1'b1, 8'h11, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 8'hE7, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 reload restarts", xfer_done, 0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R6 done after reload", xfer_done, 1);
    chk("R6 byte after reload", rx_q, 8'hE7);
    for (int i = 0; i < 9; i++) begin
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R6 no done unarmed", xfer_done, 0);
    end
  endtask

  task automatic t_clear;
    step(1'b1, 8'hA5, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    #2.5 arst = 1'b1;
    #1;
    chk("R7 async tx", tx_q, 0);
    chk("R7 async rx", rx_q, 0);
    chk("R7 async done", xfer_done, 0);
    @(negedge clk);
    arst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_known_sequence();
    t_transfer(8'h3C, 1'b0);
    t_transfer(8'h00, 1'b1);
    t_transfer(8'hB9, 1'b0);
    t_hold();
    t_priority();
    t_restart();
    t_clear();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule